// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the software-facing core of a multi-channel event timer. It decodes a 1 KB window of 32-bit registers and holds a 64-bit free-running main counter. The window contains a read-only capability word, a global configuration word, an interrupt status word and the main counter. It also contains one slot of configuration, comparator and route registers for each timer channel. Every 64-bit quantity is split into a low word and a high word four bytes above it.

Timer channel logic and interrupt routing live in neighbouring blocks. This block drives their configuration, comparator and route values and the running count on output buses. It signals them through one-cycle arm and disarm strobes, one pair per timer. Those neighbours report pending events back through a status-set input. Toggling the global enable halts or resumes the counter and re-arms or disarms the channels.

Top module: `evt_regfile`

## Requirements
- R1: The capability low word (0x000) reads vendor<<16 | bit15 (legacy route capable) | bit13 (64-bit counter) | (NUM_TIMERS-1)<<8 | revision 0x01. The high word (0x004) reads the tick period in femtoseconds. Writes to both are ignored.
- R2: The main counter advances by exactly one per clock while the global enable (bit 0 of 0x010) is 1. It holds its value while the enable is 0.
- R3: Writing 0x0F0 replaces counter bits 31:0 and writing 0x0F4 replaces bits 63:32. The other half is kept.
- R4: A 0-to-1 write of the global enable resumes counting from the held value. One cycle after the write, it pulses arm for every timer whose comparator is not all ones.
- R5: A 1-to-0 write of the global enable pulses disarm for every timer one cycle after the write, and freezes the counter.
- R6: The global configuration at 0x010 holds enable (bit 0) and legacy route (bit 1), and its other bits read 0. Its high word 0x014 reads 0 and ignores writes.
- R7: Status bit i at 0x020 is set by status-set input i and cleared by writing 1 to it. A set in the same cycle as a clear wins.
- R8: Timer i occupies 0x100+0x20*i: configuration at +0x00/+0x04, comparator at +0x08/+0x0C, route at +0x10/+0x14. After reset, the configuration low word is 0x30, its high word is 0x4 (route line 2 available), the comparator is all ones and the route is 0.
- R9: Only configuration bits 1,2,3,6,8 and 13:9 are writable (mask 0x3F4E). Bits 4 and 5 always read 1. Writes to the configuration high word are ignored.
- R10: Writing the timer enable (configuration bit 2) from 0 to 1 pulses that timer's arm one cycle later. Writing it from 1 to 0 pulses that timer's disarm.
- R11: A comparator write while globally enabled pulses that timer's arm one cycle later. A configuration write with bit 8 (32-bit mode) set clears the comparator high word.
- R12: A timer slot at an index of NUM_TIMERS or above reads 0, ignores writes and raises no strobe.
- R13: Unmapped offsets, inside and outside the timer slots, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | 32-bit write strobe |
| rd_en | input | 1 | Read enable; rdata is 0 when low |
| waddr | input | 8 | Word address (byte address bits 9:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from waddr |
| sts_set | input | NUM_TIMERS | Per-timer status set from channel logic |
| count_o | output | 64 | Main counter value |
| glb_en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy route selection |
| tmr_cfg_o | output | 32*NUM_TIMERS | Per-timer configuration low words |
| tmr_cmp_o | output | 64*NUM_TIMERS | Per-timer comparators |
| tmr_route_o | output | 64*NUM_TIMERS | Per-timer route registers |
| arm_o | output | NUM_TIMERS | One-cycle arm strobes |
| disarm_o | output | NUM_TIMERS | One-cycle disarm strobes |

## Verification
The counter is tested in three states: frozen after a half-word load, just after a resume, and free running. A frozen read pair separates hold from count, and a four-cycle spacing separates step-of-one from other rates. Arm strobes are checked with a mix of all-ones and loaded comparators, so that the all-ones exclusion shows in the strobe pattern. Configuration is written with all ones and with zeros, which exposes the write mask, the fixed bits and the enable edges. Writes to the read-only words, the upper halves, an absent timer slot and unmapped offsets each show whether a write leaks into state.

// File: rtl/evt_regs_pkg.sv
package evt_regs_pkg;

    // Word addresses (byte address >> 2) of the global registers
    localparam logic [7:0] WA_CAP_LO  = 8'h00;
    localparam logic [7:0] WA_CAP_HI  = 8'h01;
    localparam logic [7:0] WA_GCFG_LO = 8'h04;
    localparam logic [7:0] WA_GCFG_HI = 8'h05;
    localparam logic [7:0] WA_STS     = 8'h08;
    localparam logic [7:0] WA_CNT_LO  = 8'h3C;
    localparam logic [7:0] WA_CNT_HI  = 8'h3D;

    // First timer slot, in 32-byte slot units
    localparam logic [4:0] SLOT_BASE  = 5'd8;
    localparam int unsigned MAX_SLOTS = 24;

    // Word position inside a timer slot
    typedef enum logic [2:0] {
        SW_CFG_LO = 3'd0,
        SW_CFG_HI = 3'd1,
        SW_CMP_LO = 3'd2,
        SW_CMP_HI = 3'd3,
        SW_RT_LO  = 3'd4,
        SW_RT_HI  = 3'd5
    } slot_word_e;

    // Timer configuration layout
    localparam logic [31:0] TCFG_WMASK  = 32'h0000_3F4E;
    localparam logic [31:0] TCFG_FIXED  = 32'h0000_0030;
    localparam logic [31:0] TCFG_HI_VAL = 32'h0000_0004;
    localparam int unsigned TCFG_EN_BIT  = 2;
    localparam int unsigned TCFG_W32_BIT = 8;

    typedef struct packed {
        logic cfg_lo;
        logic cmp_lo;
        logic cmp_hi;
        logic rt_lo;
        logic rt_hi;
    } tmr_wr_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } glb_edge_t;

    function automatic logic [31:0] cap_low_word(input logic [15:0] vendor,
                                                 input int unsigned ntim);
        logic [31:0] w;
        w        = '0;
        w[31:16] = vendor;
        w[15]    = 1'b1;
        w[13]    = 1'b1;
        w[12:8]  = 5'(ntim - 1);
        w[7:0]   = 8'h01;
        return w;
    endfunction

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int unsigned CW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [31:0]   ld_val,
    output logic [CW-1:0] cnt
);
    localparam int unsigned HW = CW / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld_lo) begin
            cnt <= {cnt[CW-1:HW], ld_val[HW-1:0]};
        end else if (ld_hi) begin
            cnt <= {ld_val[HW-1:0], cnt[HW-1:0]};
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + 1'b1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

endmodule

// File: rtl/evt_global_regs.sv
module evt_global_regs
    import evt_regs_pkg::*;
#(
    parameter int unsigned NT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cfg,
    input  logic [1:0]    cfg_val,
    input  logic          wr_sts,
    input  logic [NT-1:0] sts_clr_val,
    input  logic [NT-1:0] sts_set,
    output logic          en_q,
    output logic          legacy_q,
    output glb_edge_t     edge_o,
    output logic [NT-1:0] sts_q
);
    always_comb begin
        edge_o.rise = wr_cfg &&  cfg_val[0] && !en_q;
        edge_o.fall = wr_cfg && !cfg_val[0] &&  en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            legacy_q <= 1'b0;
        end else if (wr_cfg) begin
            en_q     <= cfg_val[0];
            legacy_q <= cfg_val[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~(wr_sts ? sts_clr_val : '0)) | sts_set;
        end
    end

    p_sts_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && sts_clr_val[0] && !sts_set[0]) |=> !sts_q[0]);

    p_sts_set_r7: assert property (@(posedge clk) disable iff (rst)
        sts_set[0] |=> sts_q[0]);

endmodule

// File: rtl/evt_timer_slot.sv
module evt_timer_slot
    import evt_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tmr_wr_t     wr,
    input  logic [31:0] wdata,
    input  logic        glb_en,
    input  glb_edge_t   glb_edge,
    output logic [31:0] cfg_q,
    output logic [63:0] cmp_q,
    output logic [63:0] rt_q,
    output logic        arm_o,
    output logic        disarm_o
);
    logic en_rise, en_fall, arm_n, disarm_n;

    always_comb begin
        en_rise  = wr.cfg_lo && !cfg_q[TCFG_EN_BIT] &&  wdata[TCFG_EN_BIT];
        en_fall  = wr.cfg_lo &&  cfg_q[TCFG_EN_BIT] && !wdata[TCFG_EN_BIT];
        disarm_n = glb_edge.fall || en_fall;
        arm_n    = !disarm_n &&
                   ((glb_edge.rise && !(&cmp_q)) || en_rise ||
                    ((wr.cmp_lo || wr.cmp_hi) && glb_en));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= TCFG_FIXED;
            cmp_q    <= '1;
            rt_q     <= '0;
            arm_o    <= 1'b0;
            disarm_o <= 1'b0;
        end else begin
            arm_o    <= arm_n;
            disarm_o <= disarm_n;
            if (wr.cfg_lo) begin
                cfg_q <= (wdata & TCFG_WMASK) | TCFG_FIXED;
                if (wdata[TCFG_W32_BIT]) cmp_q[63:32] <= '0;
            end
            if (wr.cmp_lo) cmp_q[31:0]  <= wdata;
            if (wr.cmp_hi) cmp_q[63:32] <= wdata;
            if (wr.rt_lo)  rt_q[31:0]   <= wdata;
            if (wr.rt_hi)  rt_q[63:32]  <= wdata;
        end
    end

    p_glb_off_disarm_r5: assert property (@(posedge clk) disable iff (rst)
        glb_edge.fall |=> (disarm_o && !arm_o));

    p_enable_arm_r10: assert property (@(posedge clk) disable iff (rst)
        (wr.cfg_lo && wdata[TCFG_EN_BIT] && !cfg_q[TCFG_EN_BIT] && !glb_edge.fall)
        |=> arm_o);

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (rst)
        wr.cfg_lo |=> (cfg_q[5:4] == 2'b11));

endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_regs_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 3,
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [31:0] PERIOD_FS  = 32'd10_000_000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [7:0]               waddr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic [NUM_TIMERS-1:0]    sts_set,
    output logic [63:0]              count_o,
    output logic                     glb_en_o,
    output logic                     legacy_o,
    output logic [32*NUM_TIMERS-1:0] tmr_cfg_o,
    output logic [64*NUM_TIMERS-1:0] tmr_cmp_o,
    output logic [64*NUM_TIMERS-1:0] tmr_route_o,
    output logic [NUM_TIMERS-1:0]    arm_o,
    output logic [NUM_TIMERS-1:0]    disarm_o
);
    localparam logic [31:0] CAP_LO = cap_low_word(VENDOR_ID, NUM_TIMERS);

    initial begin
        a_tcount_range: assert (NUM_TIMERS >= 1 && NUM_TIMERS <= MAX_SLOTS)
            else $error("NUM_TIMERS out of range");
    end

    // Address decode
    logic       in_slots;
    logic [4:0] slot_idx;
    slot_word_e slot_w;
    glb_edge_t  glb_edge;
    logic [NUM_TIMERS-1:0] sts_q;

    assign in_slots = (waddr[7:6] != 2'b00);
    assign slot_idx = waddr[7:3] - SLOT_BASE;
    assign slot_w   = slot_word_e'(waddr[2:0]);

    evt_main_counter #(.CW(64)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (glb_en_o),
        .ld_lo  (wr_en && waddr == WA_CNT_LO),
        .ld_hi  (wr_en && waddr == WA_CNT_HI),
        .ld_val (wdata),
        .cnt    (count_o)
    );

    evt_global_regs #(.NT(NUM_TIMERS)) u_glb (
        .clk         (clk),
        .rst         (rst),
        .wr_cfg      (wr_en && waddr == WA_GCFG_LO),
        .cfg_val     (wdata[1:0]),
        .wr_sts      (wr_en && waddr == WA_STS),
        .sts_clr_val (wdata[NUM_TIMERS-1:0]),
        .sts_set     (sts_set),
        .en_q        (glb_en_o),
        .legacy_q    (legacy_o),
        .edge_o      (glb_edge),
        .sts_q       (sts_q)
    );

    logic [31:0] cfg_a [NUM_TIMERS];
    logic [63:0] cmp_a [NUM_TIMERS];
    logic [63:0] rt_a  [NUM_TIMERS];

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
        logic    sel;
        tmr_wr_t wr;
        assign sel       = wr_en && in_slots && (slot_idx == 5'(i));
        assign wr.cfg_lo = sel && slot_w == SW_CFG_LO;
        assign wr.cmp_lo = sel && slot_w == SW_CMP_LO;
        assign wr.cmp_hi = sel && slot_w == SW_CMP_HI;
        assign wr.rt_lo  = sel && slot_w == SW_RT_LO;
        assign wr.rt_hi  = sel && slot_w == SW_RT_HI;

        evt_timer_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr),
            .wdata    (wdata),
            .glb_en   (glb_en_o),
            .glb_edge (glb_edge),
            .cfg_q    (cfg_a[i]),
            .cmp_q    (cmp_a[i]),
            .rt_q     (rt_a[i]),
            .arm_o    (arm_o[i]),
            .disarm_o (disarm_o[i])
        );

        assign tmr_cfg_o[32*i +: 32]   = cfg_a[i];
        assign tmr_cmp_o[64*i +: 64]   = cmp_a[i];
        assign tmr_route_o[64*i +: 64] = rt_a[i];
    end

    // Read mux
    logic [31:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (in_slots) begin
            for (int i = 0; i < NUM_TIMERS; i++) begin
                if (slot_idx == 5'(i)) begin
                    case (slot_w)
                        SW_CFG_LO: rd_mux = cfg_a[i];
                        SW_CFG_HI: rd_mux = TCFG_HI_VAL;
                        SW_CMP_LO: rd_mux = cmp_a[i][31:0];
                        SW_CMP_HI: rd_mux = cmp_a[i][63:32];
                        SW_RT_LO:  rd_mux = rt_a[i][31:0];
                        SW_RT_HI:  rd_mux = rt_a[i][63:32];
                        default:   rd_mux = '0;
                    endcase
                end
            end
        end else begin
            case (waddr)
                WA_CAP_LO:  rd_mux = CAP_LO;
                WA_CAP_HI:  rd_mux = PERIOD_FS;
                WA_GCFG_LO: rd_mux = {30'd0, legacy_o, glb_en_o};
                WA_STS:     rd_mux = 32'(sts_q);
                WA_CNT_LO:  rd_mux = count_o[31:0];
                WA_CNT_HI:  rd_mux = count_o[63:32];
                default:    rd_mux = '0;
            endcase
        end
    end

    assign rdata = rd_en ? rd_mux : '0;

    p_no_strobe_clash_r10: assert property (@(posedge clk) disable iff (rst)
        (arm_o & disarm_o) == '0);

endmodule

// File: tb/tb_evt_regfile.sv
module tb_evt_regfile;
    localparam int NT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NT-1:0] sts_set = '0;
    logic [63:0] count_o;
    logic glb_en_o, legacy_o;
    logic [32*NT-1:0] tmr_cfg_o;
    logic [64*NT-1:0] tmr_cmp_o, tmr_route_o;
    logic [NT-1:0] arm_o, disarm_o;

    int total = 0;
    int bad = 0;
    logic [NT-1:0] arm_s, disarm_s;

    always #2.5 clk = ~clk;

    evt_regfile #(.NUM_TIMERS(NT)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
        .wdata(wdata), .rdata(rdata), .sts_set(sts_set), .count_o(count_o),
        .glb_en_o(glb_en_o), .legacy_o(legacy_o), .tmr_cfg_o(tmr_cfg_o),
        .tmr_cmp_o(tmr_cmp_o), .tmr_route_o(tmr_route_o),
        .arm_o(arm_o), .disarm_o(disarm_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; waddr = a[9:2]; wdata = d;
        @(posedge clk);
        #1;
        arm_s = arm_o; disarm_s = disarm_o;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; waddr = a[9:2];
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(10'h000, v); chk("R1 cap lo", v, 32'h1A2B_A201);
        rd(10'h004, v); chk("R1 cap hi", v, 32'd10_000_000);
        rd(10'h010, v); chk("R6 gcfg reset", v, 0);
        rd(10'h020, v); chk("R7 status reset", v, 0);
        rd(10'h0F0, v); chk("R2 counter reset", v, 0);
        rd(10'h120, v); chk("R8 t1 cfg lo reset", v, 32'h30);
        rd(10'h124, v); chk("R8 t1 cfg hi reset", v, 32'h4);
        rd(10'h12C, v); chk("R8 t1 cmp hi reset", v, 32'hFFFF_FFFF);
        rd(10'h150, v); chk("R8 t2 route reset", v, 0);
    endtask

    task automatic t_cap_ro();
        logic [31:0] v;
        wr(10'h000, 32'h0); wr(10'h004, 32'h0);
        rd(10'h000, v); chk("R1 cap lo after write", v, 32'h1A2B_A201);
        rd(10'h004, v); chk("R1 cap hi after write", v, 32'd10_000_000);
    endtask

    task automatic t_counter_halves();
        logic [31:0] v1, v2;
        wr(10'h0F0, 32'h1122_3344);
        wr(10'h0F4, 32'h0000_0055);
        rd(10'h0F0, v1); chk("R3 counter lo", v1, 32'h1122_3344);
        rd(10'h0F4, v2); chk("R3 counter hi", v2, 32'h55);
        wr(10'h0F0, 32'hAABB_0000);
        rd(10'h0F4, v2); chk("R3 hi kept on lo write", v2, 32'h55);
        rd(10'h0F0, v1);
        repeat (3) @(posedge clk);
        rd(10'h0F0, v2); chk("R2 counter held while disabled", v2, v1);
    endtask

    task automatic t_gcfg();
        logic [31:0] v;
        wr(10'h014, 32'hFFFF_FFFF);
        rd(10'h014, v); chk("R6 gcfg hi reads 0", v, 0);
        wr(10'h010, 32'h2);
        rd(10'h010, v); chk("R6 legacy bit", v, 32'h2);
        wr(10'h010, 32'hFFFF_FFFC);
        rd(10'h010, v); chk("R6 other bits read 0", v, 0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk); sts_set = 3'b101;
        @(negedge clk); sts_set = '0;
        rd(10'h020, v); chk("R7 status set", v, 32'h5);
        wr(10'h020, 32'h1);
        rd(10'h020, v); chk("R7 status w1c", v, 32'h4);
        @(negedge clk);
        wr_en = 1'b1; waddr = 8'h08; wdata = 32'h4; sts_set = 3'b100;
        @(negedge clk);
        wr_en = 1'b0; sts_set = '0;
        rd(10'h020, v); chk("R7 set wins over clear", v, 32'h4);
        wr(10'h020, 32'h4);
        rd(10'h020, v); chk("R7 status cleared", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v1, v2;
        // timer1 comparator loaded, timers 0 and 2 stay all ones
        wr(10'h128, 32'h100);
        chk("R11 no arm while disabled", {61'd0, arm_s}, 0);
        wr(10'h0F0, 32'h0000_0040);
        wr(10'h010, 32'h1);
        chk("R4 arm only loaded comparator", {61'd0, arm_s}, 64'b010);
        rd(10'h0F0, v1); chk("R4 resume from held value", v1, 32'h41);
        repeat (4) @(posedge clk);
        rd(10'h0F0, v2); chk("R2 step of one per cycle", v2 - v1, 4);
        wr(10'h010, 32'h0);
        chk("R5 disarm all", {61'd0, disarm_s}, 64'b111);
        rd(10'h0F0, v1);
        repeat (5) @(posedge clk);
        rd(10'h0F0, v2); chk("R5 counter frozen", v2, v1);
        rd(10'h0F4, v2); chk("R5 hi word frozen", v2, 32'h55);
    endtask

    task automatic t_tcfg();
        logic [31:0] v;
        wr(10'h100, 32'hFFFF_FFFF);
        chk("R10 enable rise arms", {61'd0, arm_s}, 64'b001);
        rd(10'h100, v); chk("R9 write mask", v, 32'h3F7E);
        rd(10'h10C, v); chk("R11 32-bit mode clears cmp hi", v, 0);
        rd(10'h108, v); chk("R11 cmp lo kept", v, 32'hFFFF_FFFF);
        wr(10'h104, 32'h0);
        rd(10'h104, v); chk("R9 cfg hi ignored", v, 32'h4);
        wr(10'h100, 32'h0);
        chk("R10 enable fall disarms", {61'd0, disarm_s}, 64'b001);
        rd(10'h100, v); chk("R9 fixed bits stay", v, 32'h30);
    endtask

    task automatic t_cmp_arm();
        logic [31:0] v;
        wr(10'h010, 32'h1);
        chk("R4 arm loaded comparators", {61'd0, arm_s}, 64'b011);
        wr(10'h148, 32'h40);
        chk("R11 comparator write arms", {61'd0, arm_s}, 64'b100);
        rd(10'h148, v); chk("R8 t2 cmp lo", v, 32'h40);
        wr(10'h154, 32'hCAFE_0001);
        rd(10'h154, v); chk("R8 t2 route hi", v, 32'hCAFE_0001);
        wr(10'h010, 32'h0);
    endtask

    task automatic t_range();
        logic [31:0] v;
        wr(10'h160, 32'hFFFF_FFFF);
        chk("R12 no strobe", {61'd0, arm_s | disarm_s}, 0);
        rd(10'h160, v); chk("R12 absent cfg reads 0", v, 0);
        wr(10'h168, 32'h1234);
        rd(10'h168, v); chk("R12 absent cmp reads 0", v, 0);
        rd(10'h140, v); chk("R12 t2 cfg untouched", v, 32'h30);
        rd(10'h3E0, v); chk("R12 top slot reads 0", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(10'h0F8, 32'hFFFF_FFFF);
        rd(10'h0F8, v); chk("R13 global hole", v, 0);
        rd(10'h118, v); chk("R13 slot hole", v, 0);
        rd(10'h030, v); chk("R13 low hole", v, 0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_cap_ro();
        t_counter_halves();
        t_gcfg();
        t_status();
        t_enable();
        t_tcfg();
        t_cmp_arm();
        t_range();
        t_unmapped();
        finish_run();
    end
endmodule